// File: doc/BRIEF.md
# Machine Trap Entry and Return Controller

This block sits between instruction fetch and the machine-mode CSR file of a single-issue RV32 core. It owns the program counter register. At every instruction boundary it decides between four outcomes: take the external interrupt, take a synchronous trap for an environment call or breakpoint, perform a trap return, or continue normally.

On a trap or a return, it computes the replacement values of the status, exception-PC and cause registers. In the same cycle it raises a single direct-write strobe, so the CSR file commits all three values together on that edge. It also raises a redirect flag with its target, which is the trap vector or the saved exception PC. Its next-PC selection ranks that redirect above any branch or jump, and a jump above sequential flow. After every trap entry it inserts one bubble.

The CSR file feeds its current status, enable, vector, exception-PC and cause values back in as inputs. The decode and execute stages supply the branch/jump decision and its target.

Top module: `trap_ctrl`

## Requirements
- R1: An interrupt is taken only in a cycle that issues an instruction while `ext_irq` is high, status bit 3 (global enable) is 1, and enable-register bit 11 (external enable) is 1.
- R2: On any trap entry, the new status has bit 7 equal to the old bit 3, and bit 3 equal to 0. All other status bits are unchanged.
- R3: On an interrupt, the new cause is 0x8000000B. The new exception PC is the jump target if `jump_flag` is high, and PC+4 otherwise. When the issued instruction is a system instruction (environment call, breakpoint or return), the new exception PC is the current PC instead, so that the instruction runs again later.
- R4: The environment call 0x00000073 writes cause 11, and the breakpoint 0x00100073 writes cause 3. Both save the current PC. If a qualifying interrupt arrives in the same cycle, the interrupt wins.
- R5: The return instruction 0x30200073 sets status bit 3 from bit 7 and sets bit 7 to 1. It redirects the PC to the exception-PC input and leaves the cause unchanged.
- R6: On trap entry, the redirect target and the next PC are the vector input with bits 1:0 forced to 0.
- R7: The next PC is chosen in this order: trap/return redirect first, then the jump target when `jump_flag` is high, then PC+4.
- R8: When `instr_valid` is low, the PC holds, `inst_o` is the NOP 0x00000013, no trap is taken, and `jump_flag` has no effect.
- R9: In the cycle after a trap entry, `inst_o` is the NOP and the PC holds at the vector, even with `instr_valid` high. No trap or interrupt is taken in that cycle.
- R10: `csr_we` and `redirect` are high exactly in cycles that apply a trap entry or a return. In all other cycles, the three next-value outputs equal the current CSR inputs.
- R11: During reset, the PC equals parameter `RESET_PC` and no bubble is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction at `pc_o` is available |
| instr | input | 32 | Instruction fetched at `pc_o` |
| jump_flag | input | 1 | Branch taken or jump in the current instruction |
| jump_target | input | 32 | Branch/jump destination |
| ext_irq | input | 1 | External interrupt request |
| csr_mstatus | input | 32 | Current status register |
| csr_mie | input | 32 | Current interrupt-enable register |
| csr_mtvec | input | 32 | Current trap vector |
| csr_mepc | input | 32 | Current exception PC |
| csr_mcause | input | 32 | Current trap cause |
| pc_o | output | 32 | Program counter |
| inst_o | output | 32 | Instruction issued to decode (NOP when squashed) |
| redirect | output | 1 | Fetch redirect by trap or return |
| redirect_addr | output | 32 | Fetch redirect target |
| csr_we | output | 1 | Direct-write strobe for the three trap CSRs |
| mstatus_nx | output | 32 | Status value to write |
| mepc_nx | output | 32 | Exception PC to write |
| mcause_nx | output | 32 | Cause to write |

## Verification
A wrong enable decode or a wrong cause selection shows on the same cycle at `csr_we`, `mcause_nx` and `mstatus_nx`, before any edge. A wrong PC register or bubble flag shows one edge later at `pc_o` and `inst_o`. The sweep combines both status bits, the external enable, the request line, five instruction kinds (including a near-miss of the return encoding), the jump flag and the valid line. Each combination starts from a distinct PC, vector and exception PC, so a swapped source or an unmasked vector bit gives a wrong value within one cycle.

// File: rtl/trap_ctrl.sv
module trap_ctrl #(
  parameter logic [31:0] RESET_PC    = 32'h0000_1000,
  parameter logic [31:0] NOP_WORD    = 32'h0000_0013,
  parameter int          IRQ_CODE    = 11,
  parameter int          ECALL_CODE  = 11,
  parameter int          EBREAK_CODE = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        instr_valid,
  input  logic [31:0] instr,
  input  logic        jump_flag,
  input  logic [31:0] jump_target,
  input  logic        ext_irq,
  input  logic [31:0] csr_mstatus,
  input  logic [31:0] csr_mie,
  input  logic [31:0] csr_mtvec,
  input  logic [31:0] csr_mepc,
  input  logic [31:0] csr_mcause,
  output logic [31:0] pc_o,
  output logic [31:0] inst_o,
  output logic        redirect,
  output logic [31:0] redirect_addr,
  output logic        csr_we,
  output logic [31:0] mstatus_nx,
  output logic [31:0] mepc_nx,
  output logic [31:0] mcause_nx
);
  localparam int          GIE_BIT  = 3;
  localparam int          PGIE_BIT = 7;
  localparam int          XIE_BIT  = 11;
  localparam logic [31:0] ENC_CALL = 32'h0000_0073;
  localparam logic [31:0] ENC_BRK  = 32'h0010_0073;
  localparam logic [31:0] ENC_RET  = 32'h3020_0073;
  localparam logic [31:0] IRQ_CAUSE = {1'b1, 31'(IRQ_CODE)};

  logic [31:0] pc_q, pc_d;
  logic        bubble_q;

  logic issue, is_call, is_brk, is_ret, is_sys;
  logic irq_take, exc_take, entry, mret_take;
  logic [31:0] pc_plus4, vec_addr, irq_epc;

  assign issue    = instr_valid & ~bubble_q;
  assign is_call  = issue & (instr == ENC_CALL);
  assign is_brk   = issue & (instr == ENC_BRK);
  assign is_ret   = issue & (instr == ENC_RET);
  assign is_sys   = is_call | is_brk | is_ret;

  assign irq_take  = issue & ext_irq & csr_mstatus[GIE_BIT] & csr_mie[XIE_BIT];
  assign exc_take  = ~irq_take & (is_call | is_brk);
  assign mret_take = ~irq_take & is_ret;
  assign entry     = irq_take | exc_take;

  assign pc_plus4 = pc_q + 32'd4;
  assign vec_addr = {csr_mtvec[31:2], 2'b00};
  assign irq_epc  = is_sys ? pc_q : (jump_flag ? jump_target : pc_plus4);

  assign redirect      = entry | mret_take;
  assign csr_we        = redirect;
  assign redirect_addr = entry ? vec_addr : csr_mepc;
  assign inst_o        = issue ? instr : NOP_WORD;
  assign pc_o          = pc_q;

  always_comb begin
    mstatus_nx = csr_mstatus;
    mepc_nx    = csr_mepc;
    mcause_nx  = csr_mcause;
    if (entry) begin
      mstatus_nx[PGIE_BIT] = csr_mstatus[GIE_BIT];
      mstatus_nx[GIE_BIT]  = 1'b0;
      if (irq_take) begin
        mepc_nx   = irq_epc;
        mcause_nx = IRQ_CAUSE;
      end else begin
        mepc_nx   = pc_q;
        mcause_nx = is_call ? 32'(ECALL_CODE) : 32'(EBREAK_CODE);
      end
    end else if (mret_take) begin
      mstatus_nx[GIE_BIT]  = csr_mstatus[PGIE_BIT];
      mstatus_nx[PGIE_BIT] = 1'b1;
    end
  end

  always_comb begin
    if (redirect)       pc_d = redirect_addr;
    else if (!issue)    pc_d = pc_q;
    else if (jump_flag) pc_d = jump_target;
    else                pc_d = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q     <= RESET_PC;
      bubble_q <= 1'b0;
    end else begin
      pc_q     <= pc_d;
      bubble_q <= entry;
    end
  end
endmodule

// File: rtl/trap_ctrl_chk.sv
module trap_ctrl_chk #(
  parameter logic [31:0] NOP_WORD = 32'h0000_0013
) (
  input logic        clk,
  input logic        rst_n,
  input logic        instr_valid,
  input logic        ext_irq,
  input logic [31:0] csr_mstatus,
  input logic [31:0] csr_mie,
  input logic [31:0] csr_mtvec,
  input logic [31:0] csr_mepc,
  input logic [31:0] csr_mcause,
  input logic [31:0] pc_o,
  input logic [31:0] inst_o,
  input logic [31:0] redirect_addr,
  input logic        csr_we,
  input logic [31:0] mstatus_nx,
  input logic [31:0] mepc_nx,
  input logic [31:0] mcause_nx,
  input logic        entry,
  input logic        mret_take
);
  a_r1_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (entry && mcause_nx == 32'h8000_000B) |-> (ext_irq && csr_mstatus[3] && csr_mie[11]));

  a_r2_entry_status: assert property (@(posedge clk) disable iff (!rst_n)
    entry |-> (!mstatus_nx[3] && mstatus_nx[7] == csr_mstatus[3]));

  a_r5_return_status: assert property (@(posedge clk) disable iff (!rst_n)
    mret_take |-> (mstatus_nx[3] == csr_mstatus[7] && mstatus_nx[7] && redirect_addr == csr_mepc));

  a_r6_vector: assert property (@(posedge clk) disable iff (!rst_n)
    entry |=> (pc_o == $past({csr_mtvec[31:2], 2'b00}) && inst_o == NOP_WORD));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |=> (pc_o == $past(pc_o)));

  a_r9_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    entry |=> !csr_we);

  a_r10_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_we |-> (mstatus_nx == csr_mstatus && mepc_nx == csr_mepc && mcause_nx == csr_mcause));
endmodule

bind trap_ctrl trap_ctrl_chk #(.NOP_WORD(NOP_WORD)) chk_i (
  .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .ext_irq(ext_irq),
  .csr_mstatus(csr_mstatus), .csr_mie(csr_mie), .csr_mtvec(csr_mtvec),
  .csr_mepc(csr_mepc), .csr_mcause(csr_mcause), .pc_o(pc_o), .inst_o(inst_o),
  .redirect_addr(redirect_addr), .csr_we(csr_we), .mstatus_nx(mstatus_nx),
  .mepc_nx(mepc_nx), .mcause_nx(mcause_nx), .entry(entry), .mret_take(mret_take)
);

// File: tb/trap_ctrl_tb_top.sv
module trap_ctrl_tb_top;
  localparam logic [31:0] RST_PC = 32'h0000_1000;
  localparam logic [31:0] NOP    = 32'h0000_0013;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [31:0] instr = NOP;
  logic        jump_flag = 1'b0;
  logic [31:0] jump_target = '0;
  logic        ext_irq = 1'b0;
  logic [31:0] csr_mstatus = '0, csr_mie = '0, csr_mtvec = '0, csr_mepc = '0, csr_mcause = '0;
  logic [31:0] pc_o, inst_o, redirect_addr, mstatus_nx, mepc_nx, mcause_nx;
  logic        redirect, csr_we;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  trap_ctrl #(.RESET_PC(RST_PC)) dut_i (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .jump_flag(jump_flag), .jump_target(jump_target), .ext_irq(ext_irq),
    .csr_mstatus(csr_mstatus), .csr_mie(csr_mie), .csr_mtvec(csr_mtvec),
    .csr_mepc(csr_mepc), .csr_mcause(csr_mcause), .pc_o(pc_o), .inst_o(inst_o),
    .redirect(redirect), .redirect_addr(redirect_addr), .csr_we(csr_we),
    .mstatus_nx(mstatus_nx), .mepc_nx(mepc_nx), .mcause_nx(mcause_nx)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input int k);
    case (k)
      0: return 32'h0050_0093;
      1: return 32'h0000_0073;
      2: return 32'h0010_0073;
      3: return 32'h3020_0073;
      default: return 32'h3020_1073;
    endcase
  endfunction

  task automatic combo(input int idx, input bit g, input bit pg, input bit xe,
                       input bit rq, input int k, input bit jf, input bit v);
    logic [31:0] start_pc, st, tgt, vec, epc, cause, nxt, e_st, e_epc, e_cause;
    bit sys, irq_t, call_t, brk_t, ret_t, ent;
    start_pc = 32'h0002_0000 + 32'(idx) * 32'd16;
    // pre-cycle: a plain jump places the PC at start_pc (R7)
    @(negedge clk);
    instr_valid = 1'b1; instr = enc(0); jump_flag = 1'b1; jump_target = start_pc;
    ext_irq = 1'b0; csr_mstatus = '0;
    @(posedge clk); #1;
    chk(pc_o == start_pc, "R7 jump target", pc_o, start_pc);

    st    = 32'h0000_1800 | (32'(g) << 3) | (32'(pg) << 7);
    tgt   = 32'h0030_0000 + 32'(idx) * 32'd8;
    vec   = 32'h0000_8003 + (32'(idx) << 8);
    epc   = 32'h0000_4000 + 32'(idx) * 32'd4;
    cause = 32'h0000_005A;
    @(negedge clk);
    instr_valid = v; instr = enc(k); jump_flag = jf; jump_target = tgt; ext_irq = rq;
    csr_mstatus = st; csr_mie = xe ? 32'h0000_0800 : 32'hFFFF_F7FF;
    csr_mtvec = vec; csr_mepc = epc; csr_mcause = cause;
    #1;
    sys    = v && (k == 1 || k == 2 || k == 3);
    irq_t  = v && rq && g && xe;
    call_t = v && !irq_t && k == 1;
    brk_t  = v && !irq_t && k == 2;
    ret_t  = v && !irq_t && k == 3;
    ent    = irq_t || call_t || brk_t;
    e_st = st; e_epc = epc; e_cause = cause;
    if (ent) begin
      e_st[7] = g; e_st[3] = 1'b0;
    end else if (ret_t) begin
      e_st[3] = pg; e_st[7] = 1'b1;
    end
    if (irq_t) begin
      e_epc = sys ? start_pc : (jf ? tgt : start_pc + 32'd4);
      e_cause = 32'h8000_000B;
    end else if (call_t || brk_t) begin
      e_epc = start_pc;
      e_cause = call_t ? 32'd11 : 32'd3;
    end
    if (ent)        nxt = {vec[31:2], 2'b00};
    else if (ret_t) nxt = epc;
    else if (!v)    nxt = start_pc;
    else if (jf)    nxt = tgt;
    else            nxt = start_pc + 32'd4;

    chk(csr_we == (ent || ret_t), "R10 direct-write strobe", 32'(csr_we), 32'(ent || ret_t));
    chk(redirect == (ent || ret_t), "R10 redirect flag", 32'(redirect), 32'(ent || ret_t));
    chk(mstatus_nx == e_st, ent ? "R2 entry status" : (ret_t ? "R5 return status" : "R10 status pass"), mstatus_nx, e_st);
    chk(mepc_nx == e_epc, irq_t ? "R3 interrupt epc" : (ent ? "R4 exception epc" : "R10 epc pass"), mepc_nx, e_epc);
    chk(mcause_nx == e_cause, irq_t ? "R1 R3 interrupt cause" : (ent ? "R4 exception cause" : "R1 R10 cause pass"), mcause_nx, e_cause);
    if (ent || ret_t)
      chk(redirect_addr == nxt, ent ? "R6 vector target" : "R5 return target", redirect_addr, nxt);
    chk(inst_o == (v ? enc(k) : NOP), "R8 issued instruction", inst_o, v ? enc(k) : NOP);
    @(posedge clk); #1;
    chk(pc_o == nxt, v ? "R7 next PC" : "R8 PC hold", pc_o, nxt);

    if (ent) begin
      @(negedge clk);
      instr_valid = 1'b1; instr = enc(k); jump_flag = 1'b1; ext_irq = 1'b1;
      csr_mstatus = 32'h0000_0008; csr_mie = 32'h0000_0800;
      #1;
      chk(inst_o == NOP, "R9 bubble NOP", inst_o, NOP);
      chk(!csr_we, "R9 no trap in bubble", 32'(csr_we), 32'd0);
      @(posedge clk); #1;
      chk(pc_o == nxt, "R9 PC held at vector", pc_o, nxt);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(pc_o == RST_PC, "R11 reset PC", pc_o, RST_PC);
    chk(inst_o == NOP, "R11 R8 reset NOP", inst_o, NOP);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk(pc_o == RST_PC, "R8 R11 hold after reset", pc_o, RST_PC);
    begin
      int idx;
      idx = 0;
      for (int g = 0; g < 2; g++)
        for (int pg = 0; pg < 2; pg++)
          for (int xe = 0; xe < 2; xe++)
            for (int rq = 0; rq < 2; rq++)
              for (int k = 0; k < 5; k++)
                for (int jf = 0; jf < 2; jf++)
                  for (int v = 0; v < 2; v++) begin
                    combo(idx, g[0], pg[0], xe[0], rq[0], k, jf[0], v[0]);
                    idx++;
                  end
    end
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule